// File: doc/BRIEF.md
# Seeded Entropy Generator with Automatic Reseeding

This block is a register-mapped random word generator. A single external entropy bit is sampled once per clock and shifted into two 32-bit registers. The seed register is filled while the block is seeding. The pool register is filled while it is generating, and each finished pool word is XORed with the seed before it is stored. Software writes a command word to start seeding or generation. It then reads a status word that tells whether the block is seeded, generating or reseeding. When a run completes, the block raises sticky completion flags and makes four or eight 32-bit result words available for reading.

After reset the block seeds itself before it accepts work. Software can trigger a fresh seed at any time by command. The block also keeps a count of delivered 16-byte units. Once that count reaches a programmed limit, the block starts a reseed on its own as soon as the current generation ends. A generation request that arrives while a seed is in progress is held and runs once the seed completes. A fixed identification word lets software confirm which block it is talking to.

Top module: `egen_top`

## Requirements
- R1: While reset is held and for the SEED_CLKS cycles of automatic seeding that follow it, status reads 0x8000_0000. Once that seeding ends, status reads 0x0000_0200.
- R2: The status word at 0x04 carries seeded in bit 9, generating in bit 30 and reseeding in bit 31. The block is idle and ready exactly when status equals 0x0000_0200.
- R3: Writing 2 to the command word at 0x00 while idle sets reseeding for exactly SEED_CLKS cycles. It loads the seed with the last 32 entropy bits and sets bit 1 (seed done) of the event word at 0x14.
- R4: Writing 1 to the command word while idle sets generating for 32 cycles per result word. Each word is the 32 entropy bits sampled for it XOR the seed. At the end, bit 0 (data ready) of the event word is set.
- R5: Bit 3 of the mode word at 0x08 selects eight words (1) or four words (0), and only that bit is stored. Results read at 0x20 + 4*k. In four-word mode, words 4 to 7 keep their earlier values.
- R6: A generate command written while a seed is running is held. Generation starts in the cycle the seed ends, so no idle status is seen between the two.
- R7: Commands written while generating, and any code other than 1 or 2, are ignored. They change neither the run length, the event word nor the results.
- R8: Event bits are sticky. Writing 1 to a bit of 0x14 clears that bit and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R9: The limit word at 0x60 counts 16-byte units: 1 per four-word run and 2 per eight-word run. When the count reaches a nonzero limit at the end of a run, a reseed of SEED_CLKS cycles follows at once and the count clears. A seed command also clears the count, and a limit of 0 never triggers a reseed.
- R10: The enable word at 0x10 stores only bits 31, 1 and 0 and has no effect on any other behaviour.
- R11: 0xF0 reads 0x0000_46BC. The command word and unmapped addresses read 0, and result words are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| entropyBit | input | 1 | Raw entropy bit sampled every cycle |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte address for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |

## Verification
The assertions check, on every cycle, a set of invariants. Generation never runs unless the block is seeded, and the seeded flag never drops. Counters stay inside their seed and word windows. A four-word run never writes the upper result words, and a result word is held unless it is being written. Data ready stays set until a write clears it. A generation in progress cannot be cut short, and a run that reaches the limit goes straight into a reseed. Only the bench scenarios can show the exact run lengths seen at the status port and the XOR of entropy with the seed in the result words. The same holds for the hand-over from a held request, the per-bit clear, the masking of the enable word and the unit counting against different limits in both modes.

// File: rtl/egen_pkg.sv
`timescale 1ns/1ps
package egen_pkg;
  localparam int RES_WORD_W = 32;
  localparam int RES_WORDS  = 8;
  localparam int RES_IDX_W  = $clog2(RES_WORDS);
  localparam int BUS_AW     = 8;
  localparam int BUS_DW     = 32;

  localparam logic [BUS_AW-1:0] ADDR_CMD   = 8'h00;
  localparam logic [BUS_AW-1:0] ADDR_STAT  = 8'h04;
  localparam logic [BUS_AW-1:0] ADDR_MODE  = 8'h08;
  localparam logic [BUS_AW-1:0] ADDR_IE    = 8'h10;
  localparam logic [BUS_AW-1:0] ADDR_EVT   = 8'h14;
  localparam logic [BUS_AW-1:0] ADDR_LIMIT = 8'h60;
  localparam logic [BUS_AW-1:0] ADDR_ID    = 8'hF0;
  localparam logic [2:0]        RES_PAGE   = 3'b001;

  localparam logic [BUS_DW-1:0] ID_CODE  = 32'h0000_46BC;
  localparam logic [BUS_DW-1:0] CODE_GEN = 32'd1;
  localparam logic [BUS_DW-1:0] CODE_SEED = 32'd2;
  localparam logic [BUS_DW-1:0] IE_MASK  = 32'h8000_0003;

  localparam int STAT_SEEDED = 9;
  localparam int STAT_GEN    = 30;
  localparam int STAT_RESEED = 31;
  localparam int MODE_BIT    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_GEN  = 2'd2
  } genState_e;

  typedef struct packed {
    logic                 shiftSeed;
    logic                 shiftPool;
    logic                 latchWord;
    logic [RES_IDX_W-1:0] wordIdx;
  } dpCtrl_t;
endpackage

// File: rtl/egen_datapath.sv
`timescale 1ns/1ps
module egen_datapath
  import egen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  entropyBit,
  input  dpCtrl_t               ctrl,
  input  logic [RES_IDX_W-1:0]  rdIdx,
  output logic [RES_WORD_W-1:0] rdWord
);
  logic [RES_WORD_W-1:0] seedQ;
  logic [RES_WORD_W-1:0] poolQ;
  logic [RES_WORD_W-1:0] resultQ [RES_WORDS];
  logic [RES_WORD_W-1:0] freshWord;

  assign freshWord = {poolQ[RES_WORD_W-2:0], entropyBit} ^ seedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedQ <= '0;
      poolQ <= '0;
    end else begin
      if (ctrl.shiftSeed) seedQ <= {seedQ[RES_WORD_W-2:0], entropyBit};
      if (ctrl.shiftPool) poolQ <= {poolQ[RES_WORD_W-2:0], entropyBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < RES_WORDS; w++) resultQ[w] <= '0;
    end else if (ctrl.latchWord) begin
      for (int w = 0; w < RES_WORDS; w++)
        if (ctrl.wordIdx == RES_IDX_W'(w)) resultQ[w] <= freshWord;
    end
  end

  assign rdWord = resultQ[rdIdx];

  for (genvar g = 0; g < RES_WORDS; g++) begin : gHold
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(ctrl.latchWord && ctrl.wordIdx == RES_IDX_W'(g)) |=> $stable(resultQ[g])); // R5
  end
endmodule

// File: rtl/egen_ctrl.sv
`timescale 1ns/1ps
module egen_ctrl
  import egen_pkg::*;
#(
  parameter int SEED_CLKS = 40,
  parameter int LIMIT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [BUS_DW-1:0] busWrData,
  output dpCtrl_t           dpCtrl,
  output logic [BUS_DW-1:0] statusWord,
  output logic              modeWide,
  output logic [BUS_DW-1:0] ieWord,
  output logic [1:0]        evtWord,
  output logic [LIMIT_W-1:0] limitWord
);
  localparam int CNT_MAX = (SEED_CLKS > RES_WORD_W) ? SEED_CLKS : RES_WORD_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SEED_LAST = CNT_W'(SEED_CLKS - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(RES_WORD_W - 1);
  localparam logic [RES_IDX_W-1:0] IDX_WIDE   = RES_IDX_W'(RES_WORDS - 1);
  localparam logic [RES_IDX_W-1:0] IDX_NARROW = RES_IDX_W'(RES_WORDS / 2 - 1);

  genState_e            state;
  logic [CNT_W-1:0]     bitCnt;
  logic [RES_IDX_W-1:0] wordIdx;
  logic                 seeded;
  logic                 pendGen;
  logic                 genWide;
  logic [LIMIT_W-1:0]   reqCnt;

  logic cmdWr, isGen, isSeed;
  logic seedEnd, wordEnd, runEnd, reseedDue;
  logic [RES_IDX_W-1:0] lastIdx;
  logic [LIMIT_W:0]     reqSum;
  logic [1:0]           evtClr, evtSet;

  assign cmdWr  = busWrEn && (busAddr == ADDR_CMD);
  assign isGen  = cmdWr && (busWrData == CODE_GEN);
  assign isSeed = cmdWr && (busWrData == CODE_SEED);

  assign lastIdx   = genWide ? IDX_WIDE : IDX_NARROW;
  assign seedEnd   = (state == ST_SEED) && (bitCnt == SEED_LAST);
  assign wordEnd   = (state == ST_GEN) && (bitCnt == WORD_LAST);
  assign runEnd    = wordEnd && (wordIdx == lastIdx);
  assign reqSum    = {1'b0, reqCnt} + (genWide ? (LIMIT_W+1)'(2) : (LIMIT_W+1)'(1));
  assign reseedDue = (limitWord != '0) && (reqSum >= {1'b0, limitWord});

  assign evtClr = (busWrEn && busAddr == ADDR_EVT) ? busWrData[1:0] : 2'b00;
  assign evtSet = {seedEnd, runEnd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWide  <= 1'b0;
      ieWord    <= '0;
      limitWord <= '0;
      evtWord   <= '0;
    end else begin
      if (busWrEn && busAddr == ADDR_MODE)  modeWide  <= busWrData[MODE_BIT];
      if (busWrEn && busAddr == ADDR_IE)    ieWord    <= busWrData & IE_MASK;
      if (busWrEn && busAddr == ADDR_LIMIT) limitWord <= busWrData[LIMIT_W-1:0];
      evtWord <= (evtWord & ~evtClr) | evtSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEED;
      bitCnt  <= '0;
      wordIdx <= '0;
      seeded  <= 1'b0;
      pendGen <= 1'b0;
      genWide <= 1'b0;
      reqCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          bitCnt  <= '0;
          wordIdx <= '0;
          if (isGen) begin
            genWide <= modeWide;
            if (seeded) state <= ST_GEN;
            else begin
              state   <= ST_SEED;
              pendGen <= 1'b1;
            end
          end else if (isSeed) begin
            state  <= ST_SEED;
            reqCnt <= '0;
          end
        end
        ST_SEED: begin
          if (isGen) pendGen <= 1'b1;
          if (seedEnd) begin
            seeded  <= 1'b1;
            bitCnt  <= '0;
            wordIdx <= '0;
            pendGen <= 1'b0;
            if (pendGen || isGen) begin
              state   <= ST_GEN;
              genWide <= modeWide;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_GEN: begin
          if (wordEnd) begin
            bitCnt <= '0;
            if (runEnd) begin
              wordIdx <= '0;
              if (reseedDue) begin
                state  <= ST_SEED;
                reqCnt <= '0;
              end else begin
                state  <= ST_IDLE;
                reqCnt <= reqSum[LIMIT_W-1:0];
              end
            end else begin
              wordIdx <= wordIdx + 1'b1;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl.shiftSeed = (state == ST_SEED);
    dpCtrl.shiftPool = (state == ST_GEN);
    dpCtrl.latchWord = wordEnd;
    dpCtrl.wordIdx   = wordIdx;
  end

  always_comb begin
    statusWord              = '0;
    statusWord[STAT_SEEDED] = seeded;
    statusWord[STAT_GEN]    = (state == ST_GEN);
    statusWord[STAT_RESEED] = (state == ST_SEED);
  end

  AST_GEN_NEEDS_SEED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GEN) |-> seeded); // R6
  AST_SEEDED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    seeded |=> seeded); // R1
  AST_SEED_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEED) |-> (bitCnt <= SEED_LAST)); // R3
  AST_WORD_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GEN) |-> (bitCnt <= WORD_LAST) && (wordIdx <= lastIdx)); // R4
  AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.latchWord && !genWide) |-> (dpCtrl.wordIdx <= IDX_NARROW)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_GEN) && !runEnd) |=> (state == ST_GEN)); // R7
  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (evtWord[0] && !evtClr[0]) |=> evtWord[0]); // R8
  AST_AUTO_RESEED: assert property (@(posedge clk) disable iff (!rstN)
    (runEnd && reseedDue) |=> (state == ST_SEED) && (reqCnt == '0)); // R9
endmodule

// File: rtl/egen_top.sv
`timescale 1ns/1ps
module egen_top
  import egen_pkg::*;
#(
  parameter int SEED_CLKS = 40,
  parameter int LIMIT_W   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        entropyBit,
  input  logic        busWrEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData
);
  dpCtrl_t               dpCtrl;
  logic [BUS_DW-1:0]     statusWord;
  logic                  modeWide;
  logic [BUS_DW-1:0]     ieWord;
  logic [1:0]            evtWord;
  logic [LIMIT_W-1:0]    limitWord;
  logic [RES_WORD_W-1:0] rdWord;
  logic                  resHit;

  egen_ctrl #(.SEED_CLKS(SEED_CLKS), .LIMIT_W(LIMIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .dpCtrl(dpCtrl), .statusWord(statusWord),
    .modeWide(modeWide), .ieWord(ieWord), .evtWord(evtWord), .limitWord(limitWord)
  );

  egen_datapath u_dp (
    .clk(clk), .rstN(rstN), .entropyBit(entropyBit), .ctrl(dpCtrl),
    .rdIdx(busAddr[RES_IDX_W+1:2]), .rdWord(rdWord)
  );

  assign resHit = (busAddr[BUS_AW-1:RES_IDX_W+2] == RES_PAGE) && (busAddr[1:0] == 2'b00);

  always_comb begin
    busRdData = '0;
    if (resHit) busRdData = rdWord;
    else begin
      unique case (busAddr)
        ADDR_STAT:  busRdData = statusWord;
        ADDR_MODE:  busRdData[MODE_BIT] = modeWide;
        ADDR_IE:    busRdData = ieWord;
        ADDR_EVT:   busRdData[1:0] = evtWord;
        ADDR_LIMIT: busRdData[LIMIT_W-1:0] = limitWord;
        ADDR_ID:    busRdData = ID_CODE;
        default:    busRdData = '0;
      endcase
    end
  end
endmodule

// File: tb/egen_top_tb.sv
`timescale 1ns/1ps
module egen_top_tb;
  localparam int SEED_T = 40;
  localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h04, A_MODE = 8'h08, A_IE = 8'h10,
                         A_EVT = 8'h14, A_LIM = 8'h60, A_ID = 8'hF0;
  localparam logic [31:0] READY = 32'h0000_0200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic entropyBit = 1'b1;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  int chkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  egen_top #(.SEED_CLKS(SEED_T)) u_dut (
    .clk(clk), .rstN(rstN), .entropyBit(entropyBit), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pollBusy(output int busy, output bit sawGen, output bit sawSeed);
    logic [31:0] s;
    busy = 0; sawGen = 0; sawSeed = 0;
    for (int i = 0; i < 5000; i++) begin
      busAddr = A_STAT;
      #1 s = busRdData;
      if (s[31] || s[30]) begin
        busy++;
        sawGen  = sawGen  | s[30];
        sawSeed = sawSeed | s[31];
      end else break;
      @(negedge clk);
    end
  endtask

  task automatic runOp(input logic [31:0] code, output int busy, output bit sawGen, output bit sawSeed);
    wr(A_CMD, code);
    pollBusy(busy, sawGen, sawSeed);
  endtask

  task automatic chkResults(input string tag, input int lo, input int hi, input logic [31:0] exp);
    for (int k = lo; k <= hi; k++) rdChk(tag, 8'h20 + 8'(4 * k), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int busy;
    bit sg, ss;
    repeat (3) @(negedge clk);
    // R1 R11: state held in reset
    rdChk("R1 status in reset", A_STAT, 32'h8000_0000);
    rdChk("R11 id word", A_ID, 32'h0000_46BC);
    rdChk("R11 result reset", 8'h24, 32'h0);
    rdChk("R8 event reset", A_EVT, 32'h0);
    rdChk("R5 mode reset", A_MODE, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R6: generate written during the automatic seed; entropy 1 -> seed all ones
    runOp(32'd1, busy, sg, ss);
    chk("R6 queued run length", 32'(busy), 32'(SEED_T + 126));
    chk("R6 saw seed then gen", {30'b0, sg, ss}, 32'h3);
    rdChk("R1 ready after seed", A_STAT, READY);
    rdChk("R2 ready word", A_STAT, READY);
    rdChk("R8 both events", A_EVT, 32'h3);
    chkResults("R4 ones xor ones", 0, 7, 32'h0);
    // R8: per-bit clear
    wr(A_EVT, 32'h0);
    rdChk("R8 write zero keeps", A_EVT, 32'h3);
    wr(A_EVT, 32'h1);
    rdChk("R8 clear bit0", A_EVT, 32'h2);
    wr(A_EVT, 32'h2);
    rdChk("R8 clear bit1", A_EVT, 32'h0);
    // R3: explicit seed with entropy 0
    entropyBit = 1'b0;
    runOp(32'd2, busy, sg, ss);
    chk("R3 seed length", 32'(busy), 32'(SEED_T));
    chk("R3 only reseeding", {30'b0, sg, ss}, 32'h1);
    rdChk("R3 seed done event", A_EVT, 32'h2);
    // R5 mode write masking
    wr(A_MODE, 32'hFFFF_FFFF);
    rdChk("R5 mode mask", A_MODE, 32'h8);
    // R4 R5: eight words, entropy 1 xor seed 0
    entropyBit = 1'b1;
    runOp(32'd1, busy, sg, ss);
    chk("R4 wide run length", 32'(busy), 32'd256);
    rdChk("R4 ready event", A_EVT, 32'h3);
    chkResults("R5 wide words", 0, 7, 32'hFFFF_FFFF);
    // R5: four words, entropy 0, upper words kept
    wr(A_MODE, 32'h0);
    entropyBit = 1'b0;
    runOp(32'd1, busy, sg, ss);
    chk("R4 narrow run length", 32'(busy), 32'd128);
    chkResults("R5 narrow low words", 0, 3, 32'h0);
    chkResults("R5 narrow upper kept", 4, 7, 32'hFFFF_FFFF);
    // R4: seed of ones inverts entropy
    entropyBit = 1'b1;
    runOp(32'd2, busy, sg, ss);
    wr(A_MODE, 32'h8);
    entropyBit = 1'b0;
    runOp(32'd1, busy, sg, ss);
    chkResults("R4 zeros xor ones", 0, 7, 32'hFFFF_FFFF);
    entropyBit = 1'b1;
    runOp(32'd1, busy, sg, ss);
    chkResults("R4 ones xor ones", 0, 7, 32'h0);
    // R7: commands while generating are ignored
    wr(A_EVT, 32'h3);
    entropyBit = 1'b0;
    wr(A_CMD, 32'd1);
    wr(A_CMD, 32'd2);
    wr(A_CMD, 32'd1);
    pollBusy(busy, sg, ss);
    chk("R7 run not extended", 32'(busy), 32'd252);
    chk("R7 no seed seen", {31'b0, ss}, 32'h0);
    rdChk("R7 no seed event", A_EVT, 32'h1);
    chkResults("R7 results", 0, 7, 32'hFFFF_FFFF);
    // R7: NOP and unknown code while idle
    entropyBit = 1'b1;
    wr(A_CMD, 32'd0);
    rdChk("R7 nop idle", A_STAT, READY);
    wr(A_CMD, 32'd3);
    rdChk("R7 code 3 idle", A_STAT, READY);
    chkResults("R7 results after nop", 0, 7, 32'hFFFF_FFFF);
    // R9: limit 3 in four-word mode
    wr(A_MODE, 32'h0);
    wr(A_LIM, 32'd3);
    rdChk("R9 limit readback", A_LIM, 32'd3);
    runOp(32'd2, busy, sg, ss);
    runOp(32'd1, busy, sg, ss);
    chk("R9 narrow unit 1", 32'(busy), 32'd128);
    runOp(32'd1, busy, sg, ss);
    chk("R9 narrow unit 2", 32'(busy), 32'd128);
    wr(A_EVT, 32'h3);
    runOp(32'd1, busy, sg, ss);
    chk("R9 narrow unit 3 reseeds", 32'(busy), 32'(128 + SEED_T));
    chk("R9 reseed seen", {31'b0, ss}, 32'h1);
    rdChk("R9 events", A_EVT, 32'h3);
    rdChk("R9 ready after", A_STAT, READY);
    runOp(32'd1, busy, sg, ss);
    chk("R9 count cleared", 32'(busy), 32'd128);
    // R9: limit 4 in eight-word mode
    wr(A_MODE, 32'h8);
    wr(A_LIM, 32'd4);
    runOp(32'd2, busy, sg, ss);
    runOp(32'd1, busy, sg, ss);
    chk("R9 wide units 2", 32'(busy), 32'd256);
    runOp(32'd1, busy, sg, ss);
    chk("R9 wide units 4 reseeds", 32'(busy), 32'(256 + SEED_T));
    // R9: limit 0 never reseeds
    wr(A_MODE, 32'h0);
    wr(A_LIM, 32'd0);
    for (int n = 0; n < 4; n++) begin
      runOp(32'd1, busy, sg, ss);
      chk("R9 limit zero", 32'(busy), 32'd128);
    end
    // R10: enable word masking, no side effect
    wr(A_IE, 32'hFFFF_FFFF);
    rdChk("R10 enable mask", A_IE, 32'h8000_0003);
    rdChk("R10 status unchanged", A_STAT, READY);
    runOp(32'd1, busy, sg, ss);
    chk("R10 run unchanged", 32'(busy), 32'd128);
    // R11: other reads
    rdChk("R11 command reads 0", A_CMD, 32'h0);
    rdChk("R11 unmapped", 8'h44, 32'h0);
    rdChk("R11 id again", A_ID, 32'h0000_46BC);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  end
endmodule